// File: doc/BRIEF.md
# Processor Identification Memory Harness

This block is a small memory target for a 6502-family processor bus. It holds a preloaded 32-byte identification program and serves it to the processor through partial address decoding, so every 16-bit address lands on one of the 32 bytes. The program probes how the attached processor decodes a few opcodes and then writes an identifier byte to address `00FF`. The harness catches that write, stops the processor and reports the identifier after checking that it is in range.

Some processors issue dummy stack writes while they are in their reset sequence. The harness keeps the store read-only until the high byte of the reset vector (`FFFD`) has been read in the current run, so those writes cannot damage the program. A bus-cycle watchdog ends a run that never reports, for example when the processor has locked up on an opcode it does not support. A `start_i` pulse reloads the image, clears the previous result and releases the processor from reset.

Each clock cycle with `phi2_i` high is one bus cycle. `rw_i` high marks a read. Writes take effect at the clock edge that ends the bus cycle. Read data is combinational from the store.

Top module: `cpu_probe_mem`

## Requirements
- R1: A bus access uses only address bits [4:0]. Any two addresses that agree in those bits reach the same byte, and a read returns the byte last accepted at that offset.
- R2: After `rst_ni` and after every `start_i`, the store holds, from offset 0: 18 5C 15 00 38 90 0D 8A 1A D0 05 6A B0 05 90 07 97 FF E8 E8 E8 E8 E8 E8 86 FF EA 4C 1E 00 A2 00. A read of `FFFC` therefore returns 1E and a read of `FFFD` returns 00.
- R3: In a run, every write before the first read of `FFFD` is discarded. This includes writes to `00FF`, which neither change the store nor end the run. Writes after that read are stored.
- R4: `data_oe_o` is high only in a read bus cycle (`phi2_i`=1, `rw_i`=1), and `data_o` is 00 whenever `data_oe_o` is low.
- R5: An accepted write to the full address `00FF` with a value other than 00 ends the run. From the next cycle, `done_o` is 1, `cpu_rdy_o` is 0 and `cpu_rst_no` is 0. `done_pulse_o` is 1 for exactly that one cycle.
- R6: An accepted write of 00 to `00FF` is stored and does not end the run.
- R7: When a run ends on a result write of value v with 1 ≤ v ≤ 6, `id_o` is v and `id_valid_o` is 1. Any other value gives `id_o` = 0 and `id_valid_o` = 0.
- R8: If the run has not ended after `WDOG_CYCLES` (default 256) bus cycles counted from `start_i`, the run ends at the last of them, with `id_o` = 0 and `id_valid_o` = 0.
- R9: `start_i` reloads the image, clears `done_o`, `id_o` and `id_valid_o`, and releases `cpu_rst_no` and `cpu_rdy_o` from the next cycle. The store is read-only again until `FFFD` is read.
- R10: After `rst_ni`, `cpu_rst_no` and `cpu_rdy_o` are 0, `done_o` and `done_pulse_o` are 0, and `id_o` is 00.
- R11: Once a run has ended, writes are ignored and the reported result does not change until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new identification run |
| addr_i | input | 16 | Processor address bus |
| rw_i | input | 1 | 1 = read, 0 = write |
| phi2_i | input | 1 | Data-phase qualifier; high marks a bus cycle |
| data_i | input | 8 | Write data from the processor |
| data_o | output | 8 | Read data to the processor, 00 when not driven |
| data_oe_o | output | 1 | Read data output enable |
| cpu_rst_no | output | 1 | Processor reset, active low |
| cpu_rdy_o | output | 1 | Processor ready / clock enable |
| done_o | output | 1 | Run has ended (level) |
| done_pulse_o | output | 1 | One-cycle pulse when the run ends |
| id_o | output | 8 | Validated processor identifier, 0 on failure |
| id_valid_o | output | 1 | Identifier lies in the defined range |

## Verification
Read data and its enable are combinational, so the bench samples them 1 ns after it drives the address, within the same bus cycle. Stored bytes, the run state and the result fields all change at the clock edge that ends a bus cycle. The bench therefore samples them 1 ns after that edge, and then checks one edge later that the done pulse has dropped. For the watchdog, the bench counts its own bus cycles from `start_i`: it checks that nothing has happened after 255 of them and that the run has ended right after the 256th.

// File: rtl/cpu_probe_pkg.sv
package cpu_probe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  localparam int unsigned IMG_BYTES   = 32;
  localparam logic [15:0] VEC_HI_ADDR = 16'hFFFD;
  localparam logic [15:0] RESULT_ADDR = 16'h00FF;
  localparam logic [7:0]  ID_MIN      = 8'd1;
  localparam logic [7:0]  ID_MAX      = 8'd6;
  localparam logic [7:0]  FILL_BYTE   = 8'hEA;

  // probe program; last six bytes double as interrupt/reset vectors
  localparam logic [0:IMG_BYTES-1][7:0] PROBE_IMG = {
    8'h18, 8'h5C, 8'h15, 8'h00, 8'h38, 8'h90, 8'h0D, 8'h8A,
    8'h1A, 8'hD0, 8'h05, 8'h6A, 8'hB0, 8'h05, 8'h90, 8'h07,
    8'h97, 8'hFF, 8'hE8, 8'hE8, 8'hE8, 8'hE8, 8'hE8, 8'hE8,
    8'h86, 8'hFF, 8'hEA, 8'h4C, 8'h1E, 8'h00, 8'hA2, 8'h00
  };

  // image sits at the top of the store so the folded vectors hit it
  function automatic logic [7:0] store_init(input int unsigned idx,
                                            input int unsigned depth);
    int unsigned base;
    base = depth - IMG_BYTES;
    if (idx >= base) return PROBE_IMG[5'(idx - base)];
    return FILL_BYTE;
  endfunction

endpackage

// File: rtl/cpu_probe_store.sv
module cpu_probe_store
  import cpu_probe_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [7:0] INIT = store_init(g, DEPTH);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[g] <= INIT;
      else if (load_i)                           mem[g] <= INIT;
      else if (wr_en_i && addr_i == ADDR_W'(g))  mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/cpu_probe_seq.sv
module cpu_probe_seq
  import cpu_probe_pkg::*;
#(
  parameter int unsigned WDOG_CYCLES = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        bus_valid_i,
  input  logic        bus_rd_i,
  input  logic [15:0] addr_i,
  input  logic        hit_i,
  output logic        run_o,
  output logic        vec_seen_o,
  output logic        timeout_o,
  output logic        cpu_rst_no,
  output logic        cpu_rdy_o
);

  localparam int unsigned CNT_W = $clog2(WDOG_CYCLES + 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q;
  logic             vec_q;
  logic             wd_last;

  assign run_o   = (phase_q == PH_RUN);
  assign wd_last = run_o && bus_valid_i && (cnt_q == CNT_W'(WDOG_CYCLES - 1));
  assign timeout_o = wd_last && !hit_i;

  always_comb begin
    phase_d = phase_q;
    if (start_i)                        phase_d = PH_RUN;
    else if (run_o && (hit_i || wd_last)) phase_d = PH_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      vec_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start_i)                  cnt_q <= '0;
      else if (run_o && bus_valid_i) cnt_q <= cnt_q + 1'b1;
      // read-only again whenever the processor is held in reset
      if (start_i || !run_o)                     vec_q <= 1'b0;
      else if (bus_rd_i && addr_i == VEC_HI_ADDR) vec_q <= 1'b1;
    end
  end

  assign vec_seen_o = vec_q;
  assign cpu_rst_no = run_o;
  assign cpu_rdy_o  = run_o;

endmodule

// File: rtl/cpu_probe_result.sv
module cpu_probe_result
  import cpu_probe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       hit_i,
  input  logic       timeout_i,
  input  logic [7:0] wdata_i,
  output logic       done_o,
  output logic       done_pulse_o,
  output logic [7:0] id_o,
  output logic       id_valid_o
);

  logic in_range;
  assign in_range = (wdata_i >= ID_MIN) && (wdata_i <= ID_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      done_pulse_o <= 1'b0;
      id_o         <= '0;
      id_valid_o   <= 1'b0;
    end else if (start_i) begin
      done_o       <= 1'b0;
      done_pulse_o <= 1'b0;
      id_o         <= '0;
      id_valid_o   <= 1'b0;
    end else begin
      done_pulse_o <= 1'b0;
      if (!done_o && (hit_i || timeout_i)) begin
        done_o       <= 1'b1;
        done_pulse_o <= 1'b1;
        id_o         <= (hit_i && in_range) ? wdata_i : 8'h00;
        id_valid_o   <= hit_i && in_range;
      end
    end
  end

endmodule

// File: rtl/cpu_probe_mem.sv
module cpu_probe_mem
  import cpu_probe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned WDOG_CYCLES = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] addr_i,
  input  logic        rw_i,
  input  logic        phi2_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  data_o,
  output logic        data_oe_o,
  output logic        cpu_rst_no,
  output logic        cpu_rdy_o,
  output logic        done_o,
  output logic        done_pulse_o,
  output logic [7:0]  id_o,
  output logic        id_valid_o
);

  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam logic [7:0]  RES_DEF = store_init(32'(RESULT_ADDR) & (DEPTH - 1), DEPTH);

  logic       bus_rd, bus_wr, wr_en, hit;
  logic       run, vec_seen, timeout;
  logic [7:0] rdata;

  assign bus_rd = phi2_i && rw_i;
  assign bus_wr = phi2_i && !rw_i;
  assign wr_en  = bus_wr && run && vec_seen;
  assign hit    = wr_en && (addr_i == RESULT_ADDR) && (data_i != RES_DEF);

  cpu_probe_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .wr_en_i (wr_en),
    .addr_i  (addr_i[ADDR_W-1:0]),
    .wdata_i (data_i),
    .rdata_o (rdata)
  );

  cpu_probe_seq #(.WDOG_CYCLES(WDOG_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .bus_valid_i (phi2_i),
    .bus_rd_i    (bus_rd),
    .addr_i      (addr_i),
    .hit_i       (hit),
    .run_o       (run),
    .vec_seen_o  (vec_seen),
    .timeout_o   (timeout),
    .cpu_rst_no  (cpu_rst_no),
    .cpu_rdy_o   (cpu_rdy_o)
  );

  cpu_probe_result u_result (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .hit_i        (hit),
    .timeout_i    (timeout),
    .wdata_i      (data_i),
    .done_o       (done_o),
    .done_pulse_o (done_pulse_o),
    .id_o         (id_o),
    .id_valid_o   (id_valid_o)
  );

  assign data_oe_o = bus_rd;
  assign data_o    = bus_rd ? rdata : 8'h00;

endmodule

// File: rtl/cpu_probe_mem_chk.sv
module cpu_probe_mem_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       cpu_rst_no,
  input logic       cpu_rdy_o,
  input logic       done_o,
  input logic       done_pulse_o,
  input logic [7:0] id_o,
  input logic       id_valid_o,
  input logic       vec_seen
);

  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == 8'h00);  // R4

  AST_DONE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cpu_rdy_o && !cpu_rst_no));  // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |=> !done_pulse_o);  // R5

  AST_PULSE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |-> (done_o && !$past(done_o)));  // R5

  AST_ID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> (id_o >= 8'd1 && id_o <= 8'd6));  // R7

  AST_ID_FAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_o |-> id_o == 8'h00);  // R7

  AST_VALID_AFTER_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_valid_o) |-> $past(vec_seen));  // R3

  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cpu_rst_no && cpu_rdy_o && !done_o));  // R9

  AST_RESET_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_no |=> !vec_seen);  // R9

endmodule

bind cpu_probe_mem cpu_probe_mem_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .data_o       (data_o),
  .data_oe_o    (data_oe_o),
  .cpu_rst_no   (cpu_rst_no),
  .cpu_rdy_o    (cpu_rdy_o),
  .done_o       (done_o),
  .done_pulse_o (done_pulse_o),
  .id_o         (id_o),
  .id_valid_o   (id_valid_o),
  .vec_seen     (vec_seen)
);

// File: tb/cpu_probe_mem_tb.sv
module cpu_probe_mem_tb;

  localparam int WDOG = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rw = 1'b1;
  logic        phi2 = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [7:0]  data_o;
  logic        data_oe_o, cpu_rst_no, cpu_rdy_o, done_o, done_pulse_o, id_valid_o;
  logic [7:0]  id_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [7:0] IMG [32] = '{
    8'h18, 8'h5C, 8'h15, 8'h00, 8'h38, 8'h90, 8'h0D, 8'h8A,
    8'h1A, 8'hD0, 8'h05, 8'h6A, 8'hB0, 8'h05, 8'h90, 8'h07,
    8'h97, 8'hFF, 8'hE8, 8'hE8, 8'hE8, 8'hE8, 8'hE8, 8'hE8,
    8'h86, 8'hFF, 8'hEA, 8'h4C, 8'h1E, 8'h00, 8'hA2, 8'h00};

  logic [7:0] ref_mem [32];

  always #5 clk = ~clk;

  cpu_probe_mem #(.WDOG_CYCLES(WDOG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .addr_i(addr), .rw_i(rw),
    .phi2_i(phi2), .data_i(din), .data_o(data_o), .data_oe_o(data_oe_o),
    .cpu_rst_no(cpu_rst_no), .cpu_rdy_o(cpu_rdy_o), .done_o(done_o),
    .done_pulse_o(done_pulse_o), .id_o(id_o), .id_valid_o(id_valid_o));

  function automatic logic [7:0] exp_id(input logic [7:0] v);
    return (v >= 8'd1 && v <= 8'd6) ? v : 8'h00;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic reload_ref();
    for (int i = 0; i < 32; i++) ref_mem[i] = IMG[i];
  endtask

  task automatic bus(input logic [15:0] a, input logic rd, input logic [7:0] wd,
                     output logic [7:0] rdv, output logic oev);
    @(negedge clk);
    phi2 = 1'b1; addr = a; rw = rd; din = wd;
    #1;
    rdv = data_o; oev = data_oe_o;
    @(posedge clk);
    #1;
    phi2 = 1'b0; rw = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v; logic oe;
    bus(a, 1'b1, 8'h00, v, oe);
    check(req, {oe, v}, {1'b1, exp});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    logic [7:0] v; logic oe;
    bus(a, 1'b0, d, v, oe);
    check(req, {oe, v}, 9'h000);  // R4 nothing driven on a write
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    reload_ref();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d, v;
    logic        r;
    void'($urandom(32'd2024));
    reload_ref();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    // R10 reset state
    check("R10", {cpu_rst_no, cpu_rdy_o, done_o, done_pulse_o, id_valid_o}, 5'b0);
    check("R10", id_o, 8'h00);
    // R4 nothing driven outside a data phase
    @(negedge clk); phi2 = 1'b0; rw = 1'b1; addr = 16'h0001; #1;
    check("R4", {data_oe_o, data_o}, 9'h000);
    rd(16'h0000, 8'h18, "R2");

    do_start();
    check("R9", {cpu_rst_no, cpu_rdy_o, done_o}, 3'b110);
    // R3 dummy stack writes and an early report are discarded
    wr(16'h01FF, 8'hAA, "R3");
    wr(16'h01FE, 8'h55, "R3");
    wr(16'h01FD, 8'h33, "R3");
    wr(16'h00FF, 8'h03, "R3");
    check("R3", done_o, 1'b0);
    rd(16'h001F, IMG[31], "R3");
    rd(16'h001E, IMG[30], "R3");
    rd(16'h001D, IMG[29], "R3");
    rd(16'hFFFC, 8'h1E, "R2");
    rd(16'hFFFD, 8'h00, "R2");

    // R1 random traffic through aliased addresses
    for (int i = 0; i < 40; i++) begin
      a = 16'($urandom);
      if (a == 16'h00FF) a = 16'h01FF;
      d = 8'($urandom);
      r = 1'($urandom);
      if (r) rd(a, ref_mem[a[4:0]], "R1");
      else begin
        wr(a, d, "R1");
        ref_mem[a[4:0]] = d;
        rd({~a[15:5], a[4:0]}, d, "R1");
      end
    end

    wr(16'h00FF, 8'h00, "R6");
    check("R6", done_o, 1'b0);
    rd(16'hE01F, 8'h00, "R6");

    wr(16'h00FF, 8'h03, "R5");
    check("R5", {done_o, done_pulse_o, cpu_rdy_o, cpu_rst_no}, 4'b1100);
    check("R7", {id_valid_o, id_o}, {1'b1, 8'h03});
    @(posedge clk); #1;
    check("R5", {done_o, done_pulse_o}, 2'b10);
    // R11 writes after the end do nothing
    wr(16'h00FF, 8'h05, "R11");
    wr(16'h0003, 8'h77, "R11");
    check("R11", {id_valid_o, id_o}, {1'b1, 8'h03});
    rd(16'h0003, ref_mem[3], "R11");
    rd(16'h001F, 8'h03, "R11");

    do_start();
    check("R9", {done_o, id_valid_o, id_o}, 10'h000);
    rd(16'h001F, IMG[31], "R9");
    rd(16'h0003, IMG[3], "R9");
    wr(16'h0003, 8'h55, "R9");
    rd(16'h0003, IMG[3], "R9");

    // R7 range validation over several runs
    for (int k = 0; k < 12; k++) begin
      case (k)
        0: v = 8'd1; 1: v = 8'd6; 2: v = 8'd7; 3: v = 8'hFF;
        default: v = 8'($urandom_range(1, 12));
      endcase
      do_start();
      rd(16'hFFFD, 8'h00, "R2");
      wr(16'h00FF, v, "R7");
      check("R7", {done_o, id_valid_o, id_o}, {1'b1, exp_id(v) != 0, exp_id(v)});
    end

    // R8 watchdog
    do_start();
    for (int i = 0; i < WDOG - 1; i++) rd(16'h0000, IMG[0], "R8");
    check("R8", done_o, 1'b0);
    rd(16'h0000, IMG[0], "R8");
    check("R8", {done_o, done_pulse_o, id_valid_o, id_o}, {3'b110, 8'h00});

    report();
  end

endmodule